// File: doc/BRIEF.md
# Long-Format Memory-Reference Execution Unit

This unit carries out the 32-bit memory-reference instructions of a small 32-bit register machine. A pulse on `start_i` makes it fetch two halfwords at the program counter: first the field halfword, then a 16-bit displacement. It then forms an effective address, performs the operation in one execute cycle and flags completion. The supported operations are address load (plain and flag-setting), word load (plain and flag-setting), call with return link, and word store.

The effective address is the sign-extended displacement plus a base. The base is a register from the 16-entry register file. Base index 0 selects the program counter instead. Because both fetches have already advanced the counter, that base value is the address of the next instruction. Destination index 0 has a meaning that depends on the opcode. For a plain load it redirects the program counter. For the flag-setting forms it drops the result and keeps only the flags. For a call it turns the call into a plain jump. For a store, index 0 reads as zero. The condition flags are exposed as `flags_o = {N, Z, V, C}` (bit 3 down to bit 0).

Top module: `mri_exec_unit`

## Requirements
- R1: After `start_i` is sampled high in idle, the two following cycles fetch at `pc` and `pc+2` with `ifetch_req_o` high. The next cycle executes. `done_o` is high for exactly one cycle, three cycles after the start edge.
- R2: The field halfword is decoded as prefix bits 15:12 = 4'hF, destination/source index bits 11:8, opcode bits 7:4 and base index bits 3:0. Opcodes are 4'h7 address load, 4'h6 address load with flags, 4'h5 load, 4'h4 load with flags, 4'h3 call and 4'h2 store.
- R3: The effective address is the base plus the sign-extended displacement. The base is r[x], or the program counter (the address after the 32-bit instruction) when x = 0.
- R4: An address load writes the effective address to r[dst]. The flag form also sets N = bit 31, Z = result zero, V = signed overflow of the add and C = carry out of the add. With dst = 0 only the flags change.
- R5: A load writes the addressed memory word to r[dst]. With dst = 0 the word is written into the program counter instead.
- R6: A load with flags sets N = bit 31, Z = word zero, V = 0 and C = any of the four bytes is zero. With dst = 0 no register is written.
- R7: A call writes the next-instruction address into r[dst] and sets the program counter to the effective address. With dst = 0 no link is kept.
- R8: A store writes r[dst] to memory at the effective address. Source index 0 stores zero.
- R9: Address load, load, call and store leave the flags unchanged.
- R10: Memory accesses are whole 32-bit words, and `mem_addr_o` has bits 1:0 forced to zero.
- R11: A wrong prefix or an unlisted opcode raises `illegal_o` together with `done_o`. It issues no memory access and changes no register and no flag. The program counter only steps past the instruction.
- R12: After reset the program counter equals `RESET_PC`, the flags are zero, and `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one instruction at the current pc (sampled in idle) |
| ifetch_req_o | output | 1 | Halfword fetch in progress |
| ifetch_addr_o | output | 32 | Halfword fetch byte address |
| ifetch_data_i | input | 16 | Fetched halfword, valid in the same cycle as the address |
| mem_req_o | output | 1 | Data word access this cycle |
| mem_we_o | output | 1 | Data access is a write |
| mem_addr_o | output | 32 | Word-aligned data byte address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid in the same cycle as the address |
| pc_o | output | 32 | Program counter |
| flags_o | output | 4 | Condition flags {N,Z,V,C} |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Instruction not recognised, valid with done_o |

## Verification
Relative to the clock edge that samples `start_i`, the field fetch is visible in the following cycle and the displacement fetch in the cycle after. The memory request appears in the third cycle. `done_o`, `illegal_o`, the new flags, the new pc and any memory write are all visible in the fourth cycle. The bench samples on falling edges, one sample per cycle from the start edge onward. It records the memory port in the execute cycle and reads results in the done cycle. Register contents are brought out with later store instructions, so each result is observed only through the memory port.

// File: rtl/mri_pkg.sv
package mri_pkg;
  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH_HI, ST_FETCH_DISP, ST_EXEC
  } mri_state_e;

  // opcode values decoded from bits 7:4 of the field halfword
  typedef enum logic [3:0] {
    OP_STORE  = 4'h2,
    OP_JSR    = 4'h3,
    OP_LOADCC = 4'h4,
    OP_LOAD   = 4'h5,
    OP_LEACC  = 4'h6,
    OP_LEA    = 4'h7
  } mri_op_e;

  typedef struct packed {
    logic [3:0] dst;
    logic [3:0] op;
    logic [3:0] x;
    logic       legal;
  } mri_dec_t;

  localparam logic [3:0] LONG_PREFIX = 4'hF;
endpackage

// File: rtl/mri_decode.sv
module mri_decode
  import mri_pkg::*;
(
  input  logic [15:0] hw_i,
  output mri_dec_t    dec_o
);
  logic known;

  always_comb begin
    unique case (hw_i[7:4])
      OP_STORE, OP_JSR, OP_LOADCC, OP_LOAD, OP_LEACC, OP_LEA: known = 1'b1;
      default: known = 1'b0;
    endcase
    dec_o.dst   = hw_i[11:8];
    dec_o.op    = hw_i[7:4];
    dec_o.x     = hw_i[3:0];
    dec_o.legal = (hw_i[15:12] == LONG_PREFIX) && known;
  end
endmodule

// File: rtl/mri_ea_unit.sv
module mri_ea_unit #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned DW   = 16
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [DW-1:0]   disp_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] ea_o,
  output logic [3:0]      add_flags_o,
  output logic [3:0]      ld_flags_o
);
  localparam int unsigned NBYTES = XLEN / 8;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN:0]   sum;
  logic [NBYTES-1:0] zb;
  logic ovf;

  assign disp_ext = {{(XLEN-DW){disp_i[DW-1]}}, disp_i};
  assign sum      = {1'b0, base_i} + {1'b0, disp_ext};
  assign ea_o     = sum[XLEN-1:0];
  assign ovf      = (base_i[XLEN-1] == disp_ext[XLEN-1]) &&
                    (sum[XLEN-1] != base_i[XLEN-1]);
  assign add_flags_o = {sum[XLEN-1], (sum[XLEN-1:0] == '0), ovf, sum[XLEN]};

  for (genvar i = 0; i < NBYTES; i++) begin : g_zb
    assign zb[i] = (ld_data_i[8*i +: 8] == 8'd0);
  end

  assign ld_flags_o = {ld_data_i[XLEN-1], (ld_data_i == '0), 1'b0, |zb};
endmodule

// File: rtl/mri_regfile.sv
module mri_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  // index 0 has no storage
  logic [XLEN-1:0] regs_q [1:NREG-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/mri_exec_unit.sv
module mri_exec_unit
  import mri_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned HW       = 16,
  parameter int unsigned NREG     = 16,
  parameter int unsigned RESET_PC = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            ifetch_req_o,
  output logic [XLEN-1:0] ifetch_addr_o,
  input  logic [HW-1:0]   ifetch_data_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [3:0]      flags_o,
  output logic            done_o,
  output logic            illegal_o
);
  localparam int unsigned RIDX  = $clog2(NREG);
  localparam int unsigned ALIGN = $clog2(XLEN / 8);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(HW / 8);

  mri_state_e      state_q, state_d;
  logic [HW-1:0]   ir_q, disp_q;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [3:0]      flags_q, flags_d;
  logic            done_q, illegal_q;

  mri_dec_t        dec;
  logic [XLEN-1:0] rd_base, rd_src, base, ea;
  logic [3:0]      add_flags, ld_flags;
  logic            in_exec, ok, rf_we;
  logic [XLEN-1:0] rf_wdata;

  mri_decode u_decode (.hw_i(ir_q), .dec_o(dec));

  mri_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
    .clk_i, .rst_ni,
    .we_i      (rf_we),
    .waddr_i   (dec.dst[RIDX-1:0]),
    .wdata_i   (rf_wdata),
    .raddr_a_i (dec.x[RIDX-1:0]),
    .raddr_b_i (dec.dst[RIDX-1:0]),
    .rdata_a_o (rd_base),
    .rdata_b_o (rd_src)
  );

  assign base = (dec.x == '0) ? pc_q : rd_base;

  mri_ea_unit #(.XLEN(XLEN), .DW(HW)) u_ea (
    .base_i      (base),
    .disp_i      (disp_q),
    .ld_data_i   (mem_rdata_i),
    .ea_o        (ea),
    .add_flags_o (add_flags),
    .ld_flags_o  (ld_flags)
  );

  assign in_exec = (state_q == ST_EXEC);
  assign ok      = in_exec && dec.legal;

  always_comb begin
    rf_we     = 1'b0;
    rf_wdata  = ea;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    pc_d      = pc_q;
    flags_d   = flags_q;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_i) state_d = ST_FETCH_HI;
      ST_FETCH_HI:   begin pc_d = pc_q + PC_STEP; state_d = ST_FETCH_DISP; end
      ST_FETCH_DISP: begin pc_d = pc_q + PC_STEP; state_d = ST_EXEC; end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (ok) begin
          unique case (dec.op)
            OP_LEA:   rf_we = (dec.dst != '0);
            OP_LEACC: begin rf_we = (dec.dst != '0); flags_d = add_flags; end
            OP_LOAD: begin
              mem_req_o = 1'b1;
              rf_wdata  = mem_rdata_i;
              rf_we     = (dec.dst != '0);
              if (dec.dst == '0) pc_d = mem_rdata_i;
            end
            OP_LOADCC: begin
              mem_req_o = 1'b1;
              rf_wdata  = mem_rdata_i;
              rf_we     = (dec.dst != '0);
              flags_d   = ld_flags;
            end
            OP_JSR: begin
              rf_wdata = pc_q;
              rf_we    = (dec.dst != '0);
              pc_d     = ea;
            end
            OP_STORE: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
            default: ;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ir_q      <= '0;
      disp_q    <= '0;
      pc_q      <= XLEN'(RESET_PC);
      flags_q   <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pc_q      <= pc_d;
      flags_q   <= flags_d;
      done_q    <= in_exec;
      illegal_q <= in_exec && !dec.legal;
      if (state_q == ST_FETCH_HI)   ir_q   <= ifetch_data_i;
      if (state_q == ST_FETCH_DISP) disp_q <= ifetch_data_i;
    end
  end

  assign ifetch_req_o  = (state_q == ST_FETCH_HI) || (state_q == ST_FETCH_DISP);
  assign ifetch_addr_o = pc_q;
  assign mem_addr_o    = {ea[XLEN-1:ALIGN], {ALIGN{1'b0}}};
  assign mem_wdata_o   = rd_src;
  assign pc_o          = pc_q;
  assign flags_o       = flags_q;
  assign done_o        = done_q;
  assign illegal_o     = illegal_q;

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_exec_to_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_exec |=> done_o);
  p_pc_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH_HI) |=> (pc_q == $past(pc_q) + PC_STEP));
  p_fetch_no_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifetch_req_o |-> !mem_req_o);
  p_illegal_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_exec && !dec.legal) |=> (illegal_o && $stable(flags_o)));
  p_word_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

// File: tb/test_mri_exec_unit.sv
`timescale 1ns/1ps
module test_mri_exec_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic        ifetch_req;
  logic [31:0] ifetch_addr;
  logic [15:0] ifetch_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] pc;
  logic [3:0]  flags;
  logic        done, illegal;

  logic [15:0] imem [1024];
  logic [31:0] dmem [64];

  int nchecks = 0;
  int nfail = 0;
  logic [31:0] epc = 32'h0;
  logic [3:0]  eflags = 4'h0;
  logic        cap_req, cap_we, cap_ill;
  logic [31:0] cap_addr;

  always #2.5 clk = ~clk;

  assign ifetch_data = imem[ifetch_addr[10:1]];
  assign mem_rdata   = dmem[mem_addr[7:2]];
  always @(posedge clk) if (mem_req && mem_we) dmem[mem_addr[7:2]] <= mem_wdata;

  mri_exec_unit i_mri_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ifetch_req_o(ifetch_req), .ifetch_addr_o(ifetch_addr), .ifetch_data_i(ifetch_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .flags_o(flags), .done_o(done), .illegal_o(illegal)
  );

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rid, act, exp);
    end
  endtask

  function automatic logic [15:0] rel(input logic [31:0] target);
    return 16'(target - (epc + 32'd4));
  endfunction

  function automatic logic [15:0] ins(input logic [3:0] d, input logic [3:0] op, input logic [3:0] x);
    return {4'hF, d, op, x};
  endfunction

  // one instruction at epc; R1 timing checked on every run
  task automatic run(input logic [15:0] hw1, input logic [15:0] disp);
    logic [31:0] p0;
    p0 = epc;
    imem[p0[10:1]] = hw1;
    imem[p0[10:1] + 10'd1] = disp;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R1 fetch req hi", {31'b0, ifetch_req}, 32'd1);
    chk("R1 fetch addr hi", ifetch_addr, p0);
    @(negedge clk);
    chk("R1 fetch addr disp", ifetch_addr, p0 + 32'd2);
    @(negedge clk);
    cap_req = mem_req; cap_we = mem_we; cap_addr = mem_addr;
    chk("R1 done early", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk("R1 done due", {31'b0, done}, 32'd1);
    cap_ill = illegal;
    epc = p0 + 32'd4;
  endtask

  task automatic finish_run(input string rid);
    chk({rid, " pc"}, pc, epc);
    chk({rid, " flags"}, {28'b0, flags}, {28'b0, eflags});
    @(negedge clk);
    chk("R1 done pulse", {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 pc", pc, 32'h0);
    chk("R12 flags", {28'b0, flags}, 32'h0);
    chk("R12 done", {31'b0, done}, 32'd0);
    chk("R12 illegal", {31'b0, illegal}, 32'd0);
  endtask

  task automatic t_load_store;
    run(ins(4'd1, 4'h5, 4'd0), rel(32'h10));
    finish_run("R5 R9 load");
    run(ins(4'd1, 4'h2, 4'd0), rel(32'h40));
    chk("R8 store req", {30'b0, cap_req, cap_we}, 32'd3);
    finish_run("R8 store");
    chk("R5 R8 stored word", dmem[16], 32'h8000_0010);
  endtask

  task automatic t_loadcc;
    run(ins(4'd2, 4'h4, 4'd0), rel(32'h14));
    eflags = 4'b0001;
    finish_run("R6 loadcc byte zero");
    run(ins(4'd9, 4'h4, 4'd0), rel(32'h24));
    eflags = 4'b1001;
    finish_run("R6 loadcc negative");
    run(ins(4'd9, 4'h2, 4'd0), rel(32'h58));
    finish_run("R6 store r9");
    chk("R6 r9 written", dmem[22], 32'hFF00_FFFF);
  endtask

  task automatic t_leacc;
    run(ins(4'd4, 4'h6, 4'd1), 16'hFFF0);
    eflags = 4'b1001;
    finish_run("R4 leacc carry");
    run(ins(4'd4, 4'h2, 4'd0), rel(32'h44));
    finish_run("R4 store r4");
    chk("R4 leacc result", dmem[17], 32'h8000_0000);
  endtask

  task automatic t_lea;
    run(ins(4'd3, 4'h7, 4'd1), 16'h0004);
    finish_run("R9 lea flags held");
    run(ins(4'd3, 4'h2, 4'd0), rel(32'h50));
    finish_run("R4 store r3");
    chk("R4 lea result", dmem[20], 32'h8000_0014);
  endtask

  task automatic t_cmpi_r0;
    run(ins(4'd5, 4'h5, 4'd0), rel(32'h18));
    finish_run("R5 load r5");
    run(ins(4'd0, 4'h6, 4'd5), 16'hFFFB);
    eflags = 4'b0101;
    finish_run("R4 compare dst0");
    run(ins(4'd0, 4'h2, 4'd0), rel(32'h48));
    finish_run("R8 store r0");
    chk("R8 r0 stores zero", dmem[18], 32'h0);
  endtask

  task automatic t_overflow;
    run(ins(4'd6, 4'h5, 4'd0), rel(32'h1C));
    finish_run("R5 load r6");
    run(ins(4'd7, 4'h6, 4'd6), 16'h0020);
    eflags = 4'b1010;
    finish_run("R4 leacc overflow");
    run(ins(4'd7, 4'h2, 4'd0), rel(32'h54));
    finish_run("R4 store r7");
    chk("R4 overflow sum", dmem[21], 32'h8000_0010);
  endtask

  task automatic t_test;
    run(ins(4'd0, 4'h4, 4'd0), rel(32'h20));
    eflags = 4'b0101;
    finish_run("R6 test zero word");
    run(ins(4'd0, 4'h4, 4'd0), rel(32'h2C));
    eflags = 4'b0000;
    finish_run("R6 test no zero byte");
    eflags = 4'b1001;
    run(ins(4'd9, 4'h4, 4'd0), rel(32'h24));
    finish_run("R6 restore flags");
  endtask

  task automatic t_unaligned;
    run(ins(4'd10, 4'h5, 4'd0), rel(32'h27));
    chk("R10 aligned address", cap_addr, 32'h24);
    finish_run("R10 load");
    run(ins(4'd10, 4'h2, 4'd0), rel(32'h5C));
    finish_run("R10 store r10");
    chk("R10 whole word", dmem[23], 32'hFF00_FFFF);
  endtask

  task automatic t_jsr;
    logic [31:0] ret;
    ret = epc + 32'd4;
    run(ins(4'd8, 4'h3, 4'd0), 16'h0040);
    epc = ret + 32'h40;
    finish_run("R7 call");
    run(ins(4'd8, 4'h2, 4'd0), rel(32'h60));
    finish_run("R7 store link");
    chk("R7 link value", dmem[24], ret);
    ret = epc + 32'd4;
    run(ins(4'd0, 4'h3, 4'd0), 16'h0020);
    epc = ret + 32'h20;
    finish_run("R7 jump");
  endtask

  task automatic t_load_pc;
    run(ins(4'd0, 4'h5, 4'd0), rel(32'h28));
    epc = 32'h300;
    finish_run("R5 load into pc");
  endtask

  task automatic t_illegal;
    run(ins(4'd1, 4'h1, 4'd0), 16'h0000);
    chk("R11 illegal opcode", {31'b0, cap_ill}, 32'd1);
    chk("R11 no access", {31'b0, cap_req}, 32'd0);
    finish_run("R11 opcode");
    dmem[25] = 32'h5555_AAAA;
    run({4'hE, 4'd1, 4'h2, 4'd0}, rel(32'h64));
    chk("R11 bad prefix", {31'b0, cap_ill}, 32'd1);
    chk("R11 bad prefix access", {31'b0, cap_req}, 32'd0);
    finish_run("R11 prefix");
    chk("R11 memory kept", dmem[25], 32'h5555_AAAA);
    run(ins(4'd1, 4'h2, 4'd0), rel(32'h68));
    chk("R2 legal clears flag", {31'b0, cap_ill}, 32'd0);
    finish_run("R11 r1 kept");
    chk("R11 r1 kept", dmem[26], 32'h8000_0010);
  endtask

  task automatic t_base_reg;
    run(ins(4'd2, 4'h2, 4'd5), 16'h0047);
    chk("R3 base plus disp", cap_addr, 32'h4C);
    finish_run("R3 store");
    chk("R3 stored", dmem[19], 32'h1200_3400);
    run(ins(4'd2, 4'h2, 4'd5), 16'hFFFF);
    chk("R3 negative disp", cap_addr, 32'h04);
    finish_run("R3 store neg");
    run(ins(4'd12, 4'h7, 4'd5), 16'h8000);
    finish_run("R3 lea sign");
    run(ins(4'd12, 4'h2, 4'd0), rel(32'h6C));
    finish_run("R3 store r12");
    chk("R3 sign extension", dmem[27], 32'hFFFF_8005);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) imem[i] = 16'h0;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    dmem[4]  = 32'h8000_0010;
    dmem[5]  = 32'h1200_3400;
    dmem[6]  = 32'h0000_0005;
    dmem[7]  = 32'h7FFF_FFF0;
    dmem[8]  = 32'h0000_0000;
    dmem[9]  = 32'hFF00_FFFF;
    dmem[10] = 32'h0000_0300;
    dmem[11] = 32'h1122_3344;
    dmem[18] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_load_store();
    t_loadcc();
    t_leacc();
    t_lea();
    t_cmpi_r0();
    t_overflow();
    t_test();
    t_unaligned();
    t_jsr();
    t_load_pc();
    t_illegal();
    t_base_reg();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule